// File: doc/BRIEF.md
# Masked Interrupt Request Generator

This block turns a set of detector outputs into a single active-low interrupt request for a host. Each detector drives one status position. A low-to-high transition on a position that carries a real event is caught and held as a pending flag. The host programs a 16-bit enable word, which it can write but not read back. That word holds one enable per event position plus a master enable in its top bit. The host reads the pending flags through a status port. The read also clears them.

The request line goes low when the master enable is set and at least one pending flag has its enable bit set. It is driven from a register, so it never glitches. Some positions carry no event: bit 15, which holds the master enable, and bits 14, 5, 2 and 1. These positions never hold a pending flag and never drive the request line. The host software decodes the status word by bit position, so the positions below are fixed.

Top module: `evt_irq_ctrl`

## Requirements
- R1: During and directly after reset, the enable word and all pending flags are zero, `irq_n` is 1 and `stat_rd_data` reads 0.
- R2: While enable bit 15 (master) is 0, `irq_n` stays 1 whatever the pending flags and other enables hold. Setting bit 15 later lets an already pending, enabled flag pull `irq_n` low.
- R3: Status positions 15, 14, 5, 2 and 1 never become pending and never pull `irq_n` low, even with the enable word all ones and those inputs toggling.
- R4: `irq_n` is registered. It goes low on the clock edge after the one at which an enabled flag becomes pending, provided master is set.
- R5: A 0-to-1 change of `src_i[k]` sampled at a clock edge sets status bit k at that edge, for each event position k. The event positions are 13 (in-band tone), 12 (four-tone set), 11 (sub-audible tone), 10 (digital squelch code), 9 and 8 (aux ADC high/low), 7 (transmit end), 6 (data transfer request), 4 (2400 b/s data), 3 (1200 b/s data) and 0 (programming flag).
- R6: `stat_rd_data` always shows the pending flags. With `stat_rd_en` high at a clock edge, all flags pending before that edge are cleared at it. `irq_n` then returns high one edge later.
- R7: A source held at 1 sets its flag only once. Holding the level does not set the flag again after it is cleared.
- R8: A rising edge sampled in the same cycle as a status read is kept pending after the read.
- R9: A pending flag whose enable bit is 0 does not pull `irq_n` low. Writing its enable bit to 1 later, with master set, does pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Detector levels, one per status position |
| mask_wr_en | input | 1 | Write strobe for the enable word |
| mask_wr_data | input | 16 | New enable word, bit 15 is master |
| stat_rd_en | input | 1 | Status read strobe, clears pending flags |
| stat_rd_data | output | 16 | Pending flags |
| irq_n | output | 1 | Active-low registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit word, master enable at bit 15, and reserved positions 14, 5, 2 and 1. These values make every fixed-position case reachable. They cover a reserved-bit storm under an all-ones enable word and a master bit that gates an already pending flag. They also cover an edge that lands in the same cycle as a clearing read, and a source held high across a clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int unsigned EVT_W      = 16;
    localparam int unsigned MASTER_POS = 15;
    localparam logic [EVT_W-1:0] RSVD_POS = 16'h4026;

    typedef logic [EVT_W-1:0] evt_vec_t;

    typedef struct packed {
        logic     master;
        evt_vec_t enables;
    } irq_cfg_t;

    function automatic evt_vec_t event_positions(input evt_vec_t rsvd, input int unsigned mpos);
        evt_vec_t v;
        v = ~rsvd;
        v[mpos] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // sampled also during reset so a level held through reset is not an edge
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            assign rise_o[i] = lvl_i[i] & ~prev_q[i];
        end else begin : g_dead
            assign rise_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/evt_pend_reg.sv
module evt_pend_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;
    logic [W-1:0] kept;

    always_comb begin
        kept = clr_i ? '0 : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= kept | set_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [W-1:0]             pend_i,
    input  evt_irq_pkg::irq_cfg_t    cfg_i,
    output logic                     irq_n_o
);
    logic any_hit;

    always_comb begin
        any_hit = |(pend_i & cfg_i.enables[W-1:0] & LIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_n_o <= 1'b1;
        else     irq_n_o <= ~(cfg_i.master & any_hit);
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int unsigned W = evt_irq_pkg::EVT_W,
    parameter int unsigned MPOS = evt_irq_pkg::MASTER_POS,
    parameter logic [W-1:0] RSVD = evt_irq_pkg::RSVD_POS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_i,
    input  logic         mask_wr_en,
    input  logic [W-1:0] mask_wr_data,
    input  logic         stat_rd_en,
    output logic [W-1:0] stat_rd_data,
    output logic         irq_n
);
    import evt_irq_pkg::*;

    localparam logic [W-1:0] LIVE = event_positions(RSVD, MPOS);

    logic [W-1:0] mask_q;
    logic [W-1:0] rise;
    irq_cfg_t     cfg;

    always_ff @(posedge clk) begin
        if (rst)             mask_q <= '0;
        else if (mask_wr_en) mask_q <= mask_wr_data & ~RSVD;
    end

    always_comb begin
        cfg.master  = mask_q[MPOS];
        cfg.enables = mask_q & LIVE;
    end

    evt_edge_det #(.W(W), .LIVE(LIVE)) u_edge (
        .clk   (clk),
        .lvl_i (src_i),
        .rise_o(rise)
    );

    evt_pend_reg #(.W(W)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (rise),
        .clr_i (stat_rd_en),
        .pend_o(stat_rd_data)
    );

    evt_irq_out #(.W(W), .LIVE(LIVE)) u_out (
        .clk    (clk),
        .rst    (rst),
        .pend_i (stat_rd_data),
        .cfg_i  (cfg),
        .irq_n_o(irq_n)
    );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int unsigned W = 16,
    parameter int unsigned MPOS = 15,
    parameter logic [W-1:0] RSVD = '0
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] src_i,
    input logic         stat_rd_en,
    input logic [W-1:0] stat_rd_data,
    input logic         irq_n,
    input logic [W-1:0] mask_q
);
    localparam logic [W-1:0] LIVE = evt_irq_pkg::event_positions(RSVD, MPOS);

    logic [W-1:0] ck_prev;
    logic [W-1:0] ck_rise;

    always_ff @(posedge clk) ck_prev <= src_i;
    assign ck_rise = src_i & ~ck_prev & LIVE;

    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> irq_n); // R1
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst) !mask_q[MPOS] |=> irq_n); // R2
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst) (stat_rd_data & ~LIVE) == '0); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past(mask_q[MPOS] && ((stat_rd_data & mask_q) != '0))); // R4
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (ck_rise != '0) |=> (stat_rd_data & $past(ck_rise)) == $past(ck_rise)); // R5
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        stat_rd_en |=> (stat_rd_data & ~$past(src_i)) == '0); // R6
endmodule

bind evt_irq_ctrl evt_irq_chk #(.W(W), .MPOS(MPOS), .RSVD(RSVD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_i       (src_i),
    .stat_rd_en  (stat_rd_en),
    .stat_rd_data(stat_rd_data),
    .irq_n       (irq_n),
    .mask_q      (mask_q)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_i = '0;
    logic        mask_wr_en = 1'b0;
    logic [15:0] mask_wr_data = '0;
    logic        stat_rd_en = 1'b0;
    logic [15:0] stat_rd_data;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_stat;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk(clk), .rst(rst), .src_i(src_i),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data), .irq_n(irq_n)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic exp_irq(input logic v, input string tag);
        item_t it;
        it.is_stat = 1'b0; it.exp = {15'b0, v}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_stat(input logic [15:0] v, input string tag);
        item_t it;
        it.is_stat = 1'b1; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr_mask(input logic [15:0] v);
        mask_wr_en = 1'b1; mask_wr_data = v;
        step();
        mask_wr_en = 1'b0;
    endtask

    task automatic read_stat(input logic [15:0] v, input string tag);
        stat_rd_en = 1'b1;
        exp_stat(v, tag);
        step();
        stat_rd_en = 1'b0;
    endtask

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            act = it.is_stat ? stat_rd_data : {15'b0, irq_n};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s actual=%h expected=%h", it.tag,
                         it.is_stat ? "stat" : "irq_n", act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) step();
        exp_irq(1'b1, "R1"); exp_stat(16'h0000, "R1");
        rst = 1'b0;
        step();
        exp_irq(1'b1, "R1");

        // enabled source, latency
        wr_mask(16'hA000);
        src_i = 16'h2000;
        step();
        exp_stat(16'h2000, "R5"); exp_irq(1'b1, "R4");
        step();
        exp_irq(1'b0, "R4");

        // held level, clear on read
        step(); step();
        exp_stat(16'h2000, "R7");
        read_stat(16'h2000, "R6");
        exp_stat(16'h0000, "R6"); exp_irq(1'b0, "R4");
        step();
        exp_irq(1'b1, "R6"); exp_stat(16'h0000, "R7");
        src_i = '0;
        step();

        // master off
        wr_mask(16'h2000);
        step();
        src_i = 16'h2000;
        step();
        exp_stat(16'h2000, "R2");
        step(); step();
        exp_irq(1'b1, "R2");
        wr_mask(16'hA000);
        step();
        exp_irq(1'b0, "R2");
        src_i = '0;
        read_stat(16'h2000, "R6");
        step();
        exp_irq(1'b1, "R6");

        // reserved positions
        wr_mask(16'hFFFF);
        src_i = 16'hC026;
        step(); step(); step();
        exp_stat(16'h0000, "R3"); exp_irq(1'b1, "R3");
        src_i = '0;
        step();
        src_i = 16'hC026;
        step(); step();
        exp_stat(16'h0000, "R3"); exp_irq(1'b1, "R3");
        src_i = '0;
        step();

        // edge during read
        src_i = 16'h0008;
        step();
        exp_stat(16'h0008, "R5");
        src_i = 16'h0018;
        read_stat(16'h0008, "R8");
        exp_stat(16'h0010, "R8");
        src_i = '0;
        read_stat(16'h0010, "R8");
        step();
        exp_irq(1'b1, "R6");

        // per-bit enable
        wr_mask(16'h8001);
        src_i = 16'h0080;
        step(); step(); step();
        exp_stat(16'h0080, "R9"); exp_irq(1'b1, "R9");
        wr_mask(16'h8081);
        step();
        exp_irq(1'b0, "R9");
        src_i = '0;
        read_stat(16'h0080, "R6");
        step();
        exp_irq(1'b1, "R9");

        // every event position at once
        src_i = 16'hFFFF;
        step();
        exp_stat(16'h3FD9, "R5");
        read_stat(16'h3FD9, "R5");
        step();
        exp_stat(16'h0000, "R7");
        step();
        exp_irq(1'b1, "R9");

        // programming flag alone with its enable
        src_i = '0;
        step();
        src_i = 16'h0001;
        step();
        exp_stat(16'h0001, "R5");
        step();
        exp_irq(1'b0, "R4");
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule